// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor

This block adds or subtracts two W-bit two's-complement operands in a single combinational path. One control input selects the operation. Both operations use the same ripple chain of full adders. For subtraction, every bit of the second operand is inverted and a 1 is fed into the low carry. The result is therefore the first operand plus the two's complement of the second.

Besides the W-bit result, the block reports two flags. The first is the raw carry out of the top bit, which an unsigned caller can read as a no-borrow indication when subtracting. The second is a signed-overflow flag, derived from the carries entering and leaving the sign position. The block holds no state, and its outputs follow its inputs within the adder's propagation delay.

Top module: `addsub_core`

## Requirements
- R1: With sub_i = 0 (add), sum_o equals (a_i + b_i) modulo 2^W.
- R2: With sub_i = 1 (subtract), sum_o equals (a_i - b_i) modulo 2^W. When b_i is larger than a_i as signed values, the result is the negative two's-complement difference.
- R3: carry_o is the carry out of bit W-1 of a_i + (b_i XOR {W{sub_i}}) + sub_i. In add mode it is 1 exactly when the unsigned sum reaches 2^W. In subtract mode it is 1 exactly when a_i >= b_i as unsigned values.
- R4: ovf_o is 1 exactly when the signed result of the selected operation lies outside the range -2^(W-1) to 2^(W-1)-1. This means two like-signed operands gave a sum of the opposite sign.
- R5: At W = 4, -7 + 7 and 5 + (-3) each give carry_o = 1 with ovf_o = 0. 4 + 4 gives ovf_o = 1 with carry_o = 0.
- R6: Subtracting the most negative value, -2^(W-1), from any non-negative operand sets ovf_o.
- R7: Subtracting zero returns a_i unchanged, with carry_o = 1 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand (minuend when subtracting) |
| b_i | input | W | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | 0 selects add, 1 selects subtract |
| sum_o | output | W | Result, W-bit two's complement |
| carry_o | output | 1 | Carry out of the sign position |
| ovf_o | output | 1 | Signed overflow |

## Verification
At W = 4 the bench applies all 256 operand pairs in both modes. It compares the result, the carry and the overflow flag against a signed integer model. The sweep separates cases where a carry appears without signed overflow from cases where overflow appears without a carry. This catches a flag wrongly taken from the carry-out alone. Directed cases then cover the three named pairs, subtraction of the most negative value, and subtraction of zero. These separate a missing carry-in injection from a missing operand inversion.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DEF_WIDTH = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/addsub_fa.sv
// Full adder built from two half adders and an OR.
module addsub_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic hs, hc0, hc1;

  always_comb begin
    hs  = x_i ^ y_i;
    hc0 = x_i & y_i;
    s_o = hs ^ c_i;
    hc1 = hs & c_i;
    c_o = hc0 | hc1;
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int unsigned W = addsub_pkg::DEF_WIDTH
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic         msb_cin_o,
  output logic         cout_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    addsub_fa i_fa (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (chain[k]),
      .s_o (s_o[k]),
      .c_o (chain[k+1])
    );
  end

  assign msb_cin_o = chain[W-1];
  assign cout_o    = chain[W];
endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf (
  input  logic msb_cin_i,
  input  logic msb_cout_i,
  output logic ovf_o
);
  assign ovf_o = msb_cin_i ^ msb_cout_i;
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int unsigned W = addsub_pkg::DEF_WIDTH
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  import addsub_pkg::*;

  op_e         op;
  logic [W-1:0] b_cond;
  logic         msb_cin;

  assign op     = op_e'(sub_i);
  // Conditional inversion; the low carry completes the two's complement.
  assign b_cond = b_i ^ {W{op == OP_SUB}};

  addsub_ripple #(.W(W)) i_ripple (
    .x_i       (a_i),
    .y_i       (b_cond),
    .cin_i     (op == OP_SUB),
    .s_o       (sum_o),
    .msb_cin_o (msb_cin),
    .cout_o    (carry_o)
  );

  addsub_ovf i_ovf (
    .msb_cin_i  (msb_cin),
    .msb_cout_i (carry_o),
    .ovf_o      (ovf_o)
  );
endmodule

// File: rtl/addsub_core_chk.sv
module addsub_core_chk #(
  parameter int unsigned W = addsub_pkg::DEF_WIDTH
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic [W-1:0] sum_o,
  input logic         carry_o,
  input logic         ovf_o
);
  logic signed [W+1:0] sa, sb, sres;
  logic [W:0]          ua, ub, uadd;
  logic [W-1:0]        diff;

  always_comb begin
    sa   = {{2{a_i[W-1]}}, a_i};
    sb   = {{2{b_i[W-1]}}, b_i};
    sres = sub_i ? (sa - sb) : (sa + sb);
    ua   = {1'b0, a_i};
    ub   = {1'b0, b_i};
    uadd = ua + ub;
    diff = a_i - b_i;
    if (!sub_i) begin
      assert_add_sum_R1: assert (sum_o == uadd[W-1:0]);
      assert_add_carry_R3: assert (carry_o == uadd[W]);
    end else begin
      assert_sub_sum_R2: assert (sum_o == diff);
      assert_sub_carry_R3: assert (carry_o == (a_i >= b_i));
    end
    assert_ovf_range_R4: assert (ovf_o == (sres[W] != sres[W-1]));
  end
endmodule

bind addsub_core addsub_core_chk #(.W(W)) i_addsub_core_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .sub_i   (sub_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/test_addsub_core.sv
module test_addsub_core;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic sub_i = 1'b0;
  logic [W-1:0] sum_o;
  logic carry_o, ovf_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addsub_core #(.W(W)) i_addsub_core (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .sum_o(sum_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  function automatic int sval(int u);
    return (u >= M/2) ? u - M : u;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d sub=%0d act=%0d exp=%0d", tag, a_i, b_i, sub_i, act, exp);
    end
  endtask

  task automatic apply(int a, int b, bit s);
    @(posedge clk);
    a_i = W'(a); b_i = W'(b); sub_i = s;
    @(negedge clk);
  endtask

  task automatic full(int a, int b, bit s);
    int r;
    apply(a, b, s);
    r = s ? sval(a) - sval(b) : sval(a) + sval(b);
    chk(s ? "R2 sum" : "R1 sum", int'(sum_o), (s ? a - b : a + b) & (M - 1));
    chk("R3 carry", int'(carry_o), s ? int'(a >= b) : int'(a + b >= M));
    chk("R4 ovf", int'(ovf_o), int'(r > M/2 - 1 || r < -M/2));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle sum", int'(sum_o), 0);
    chk("R4 idle ovf", int'(ovf_o), 0);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          full(a, b, bit'(s));
    // R5 named pairs
    apply(M - 7, 7, 0);
    chk("R5 -7+7 carry", int'(carry_o), 1); chk("R5 -7+7 ovf", int'(ovf_o), 0);
    apply(5, M - 3, 0);
    chk("R5 5+-3 carry", int'(carry_o), 1); chk("R5 5+-3 ovf", int'(ovf_o), 0);
    apply(4, 4, 0);
    chk("R5 4+4 carry", int'(carry_o), 0); chk("R5 4+4 ovf", int'(ovf_o), 1);
    // R6 subtract most negative value
    for (int a = 0; a < M/2; a++) begin
      apply(a, M/2, 1);
      chk("R6 ovf", int'(ovf_o), 1);
    end
    // R7 subtract zero
    for (int a = 0; a < M; a++) begin
      apply(a, 0, 1);
      chk("R7 sum", int'(sum_o), a);
      chk("R7 carry", int'(carry_o), 1);
      chk("R7 ovf", int'(ovf_o), 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule